// File: doc/BRIEF.md
# Serial Flash Boot-Mode Command Sequencer

This block is the control engine that runs in-system reprogramming of an on-chip flash array over a serial byte link, once the chip has started in its serial boot mode. It holds off until an external detector reports that the link bit rate is locked. It then answers host inquiries about the array and the device. On the host's "enter program/erase" command it forces a full erase of the user array. Only after that erase does it accept program, block-erase, sum-check, blank-check, read and status commands.

Program and block-erase selections are sticky. After selection, the host may send any number of program or erase sequences. Each one is acknowledged when its flash work has finished. A sentinel value ends the selection: an all-ones start address for program, block number 0xFF for erase. The sentinel returns the block to command waiting and performs no flash operation.

Toward the flash, the block issues one operation at a time over a request/acknowledge pair. Toward the link, it accepts bytes with a valid/ready pair and emits response bytes as single-cycle strobes. No byte is accepted while a flash operation or a response is pending.

Top module: `boot_cmd_sequencer`

## Requirements
- R1: While `baud_locked` has not yet been seen high, `rx_ready` stays low, no response byte is sent and no flash request is raised.
- R2: In the inquiry phase, byte 0x20 returns the array size in bytes (4 bytes, MSB first). Byte 0x21 returns the user array start address (4 bytes, MSB first). Byte 0x22 returns the 16-bit device code (2 bytes, MSB first).
- R3: In the inquiry phase, byte 0x40 raises exactly one flash request with `fl_op` = 0 (full erase). Response 0x06 follows once the flash acknowledges, and the block enters command waiting.
- R4: Before the full erase has completed, command-phase codes such as 0x43 are answered with 0x15 and cause no flash request.
- R5: After program select (0x43 → 0x06), a sequence of 0x50, a 4-byte start address (MSB first) and PAYLOAD data bytes issues one `fl_op` = 2 request per data byte, at addresses start+0 to start+PAYLOAD-1, carrying that byte. Response 0x06 follows the last write, and the block keeps waiting for a further 0x50.
- R6: A program sequence whose start address is 0xFFFFFFFF answers 0x06, writes nothing and returns the block to command waiting.
- R7: After erase select (0x48 → 0x06), a sequence of 0x45 and a block number below NUM_BLOCKS issues one `fl_op` = 1 request with `fl_addr` equal to the block number. Response 0x06 follows, and the block keeps waiting for a further 0x45.
- R8: Block number 0xFF answers 0x06, erases nothing and returns the block to command waiting.
- R9: An unknown command code, or a block number from NUM_BLOCKS to 0xFE, answers 0x15 and leaves the state as it was.
- R10: Sum check (0x4B) reads every array address 0 to ARRAY_BYTES-1 with `fl_op` = 3. It returns the 32-bit byte-wise sum, 4 bytes MSB first.
- R11: Blank check (0x4C) reads the whole array. It answers 0x06 if every byte is 0xFF and 0x15 otherwise.
- R12: Read (0x52) followed by a 4-byte address (MSB first) returns the one byte stored there.
- R13: `fl_req`, `fl_op` and `fl_addr` hold until `fl_ack`. While `fl_req` is high, `rx_ready` is low and no response byte is sent.
- R14: Status query (0x4F) in command waiting returns the state code 0x03.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_locked | input | 1 | Bit-rate detection finished |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Byte taken on this edge when rx_valid is high |
| tx_valid | output | 1 | Response byte strobe, one cycle per byte |
| tx_data | output | 8 | Response byte |
| fl_req | output | 1 | Flash operation request, held until acknowledge |
| fl_op | output | 2 | 0 full erase, 1 block erase, 2 program, 3 read |
| fl_addr | output | 32 | Byte address, or block number for block erase |
| fl_wdata | output | 8 | Byte to program |
| fl_ack | input | 1 | Flash operation finished |
| fl_rdata | input | 8 | Read data, valid with fl_ack |

## Verification
A wrong internal state shows up on the very next host byte. The byte gets the wrong answer (0x15 instead of 0x06 or the reverse), or a flash request appears or fails to appear within a few cycles. The status query exposes the state code directly after each sentinel. Counting errors surface only at the end of a multi-byte exchange: a miscounted payload or address byte shows up as a missing 0x06 or a shifted write address. The bench therefore logs every flash request and compares the whole log after each sequence. Sum check turns any stray or missing write into a wrong 4-byte total.

// File: rtl/boot_seq_pkg.sv
// Shared types and code values for the boot-mode command sequencer.
package boot_seq_pkg;

    // Sequencer states; the numeric value of S_CMD is reported by the status query.
    typedef enum logic [3:0] {
        S_MATCH     = 4'd0,
        S_INQ       = 4'd1,
        S_FERASE    = 4'd2,
        S_CMD       = 4'd3,
        S_PROG_CODE = 4'd4,
        S_PROG_ADDR = 4'd5,
        S_PROG_DATA = 4'd6,
        S_ERA_CODE  = 4'd7,
        S_ERA_BLK   = 4'd8,
        S_RD_ADDR   = 4'd9,
        S_RD_WAIT   = 4'd10,
        S_SCAN      = 4'd11
    } seq_state_e;

    // Flash-side operation encoding.
    typedef enum logic [1:0] {
        OP_FULL = 2'd0,
        OP_BLK  = 2'd1,
        OP_PROG = 2'd2,
        OP_READ = 2'd3
    } flash_op_e;

    localparam logic [7:0] CMD_Q_SIZE = 8'h20;
    localparam logic [7:0] CMD_Q_BASE = 8'h21;
    localparam logic [7:0] CMD_Q_DEV  = 8'h22;
    localparam logic [7:0] CMD_GO_PE  = 8'h40;
    localparam logic [7:0] CMD_PSEL   = 8'h43;
    localparam logic [7:0] CMD_ESEL   = 8'h48;
    localparam logic [7:0] CMD_SUM    = 8'h4B;
    localparam logic [7:0] CMD_BLANK  = 8'h4C;
    localparam logic [7:0] CMD_STAT   = 8'h4F;
    localparam logic [7:0] CMD_READ   = 8'h52;
    localparam logic [7:0] SEQ_PROG   = 8'h50;
    localparam logic [7:0] SEQ_ERASE  = 8'h45;
    localparam logic [7:0] BLK_END    = 8'hFF;
    localparam logic [7:0] RSP_ACK    = 8'h06;
    localparam logic [7:0] RSP_NAK    = 8'h15;

endpackage

// File: rtl/boot_tx_serializer.sv
// Response serializer: takes a word of 1..4 bytes and emits them MSB first,
// one byte per cycle. Assumes load is never raised while busy is high.
module boot_tx_serializer (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] load_word,
    input  logic [2:0]  load_len,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        busy
);
    logic [31:0] buf_q;
    logic [2:0]  cnt_q;
    logic [5:0]  shamt;

    // Left-align the valid bytes so the first one sits in the top byte.
    assign shamt = {3'd4 - load_len, 3'b000};

    // Load or shift the response word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            buf_q <= load_word << shamt;
            cnt_q <= load_len;
        end else if (cnt_q != 3'd0) begin
            buf_q <= {buf_q[23:0], 8'h00};
            cnt_q <= cnt_q - 3'd1;
        end
    end

    assign tx_valid = (cnt_q != 3'd0);
    assign tx_data  = buf_q[31:24];
    assign busy     = tx_valid;
endmodule

// File: rtl/boot_flash_port.sv
// Flash request port: latches one operation on iss and holds the request
// until the flash acknowledges, then pulses done with the read byte.
// Assumes iss is never raised while a request is outstanding.
module boot_flash_port
    import boot_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        iss,
    input  flash_op_e   iss_op,
    input  logic [31:0] iss_addr,
    input  logic [7:0]  iss_wdata,
    output logic        fl_req,
    output logic [1:0]  fl_op,
    output logic [31:0] fl_addr,
    output logic [7:0]  fl_wdata,
    input  logic        fl_ack,
    input  logic [7:0]  fl_rdata,
    output logic        done,
    output logic [7:0]  rdata
);
    // Request hold and completion capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_req   <= 1'b0;
            fl_op    <= 2'd0;
            fl_addr  <= '0;
            fl_wdata <= '0;
            done     <= 1'b0;
            rdata    <= '0;
        end else begin
            done <= 1'b0;
            if (iss) begin
                fl_req   <= 1'b1;
                fl_op    <= iss_op;
                fl_addr  <= iss_addr;
                fl_wdata <= iss_wdata;
            end else if (fl_req && fl_ack) begin
                fl_req <= 1'b0;
                done   <= 1'b1;
                rdata  <= fl_rdata;
            end
        end
    end
endmodule

// File: rtl/boot_seq_ctrl.sv
// Command state machine: decodes host bytes per phase, issues flash
// operations one at a time and queues response words. Assumes the
// serializer and flash port report busy/done as wired in the top.
module boot_seq_ctrl
    import boot_seq_pkg::*;
#(
    parameter int          ARRAY_BYTES = 256,
    parameter int          NUM_BLOCKS  = 8,
    parameter int          PAYLOAD     = 128,
    parameter logic [31:0] USER_BASE   = 32'h0000_8000,
    parameter logic [15:0] DEVICE_ID   = 16'h0A31
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        baud_locked,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    output logic        rx_ready,
    input  logic        tx_busy,
    output logic        tx_load,
    output logic [31:0] tx_word,
    output logic [2:0]  tx_len,
    output logic        iss,
    output flash_op_e   iss_op,
    output logic [31:0] iss_addr,
    output logic [7:0]  iss_wdata,
    input  logic        op_done,
    input  logic [7:0]  op_rdata,
    output seq_state_e  state
);
    localparam int AW = $clog2(ARRAY_BYTES);
    localparam int CW = $clog2(PAYLOAD) + 1;
    localparam logic [AW-1:0] LAST_SCAN = AW'(ARRAY_BYTES - 1);
    localparam logic [CW-1:0] LAST_BYTE = CW'(PAYLOAD - 1);

    logic          pend;
    seq_state_e    after_q;
    logic          ack_q;
    logic [31:0]   addr_q;
    logic [31:0]   addr_nx;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] scan_addr;
    logic          scan_sum;
    logic [31:0]   sum_q;
    logic          blank_q;
    logic          accepting;
    logic          take;

    // Byte-collecting states that may take a host byte.
    always_comb begin
        unique case (state)
            S_INQ, S_CMD, S_PROG_CODE, S_PROG_ADDR, S_PROG_DATA,
            S_ERA_CODE, S_ERA_BLK, S_RD_ADDR: accepting = 1'b1;
            default:                          accepting = 1'b0;
        endcase
    end

    assign rx_ready = accepting && !pend && !tx_load && !tx_busy;
    assign take     = rx_valid && rx_ready;
    assign addr_nx  = {addr_q[23:0], rx_data};

    // Main sequencer: completion handling first, then byte decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_MATCH;
            after_q   <= S_CMD;
            ack_q     <= 1'b0;
            pend      <= 1'b0;
            addr_q    <= '0;
            cnt_q     <= '0;
            scan_addr <= '0;
            scan_sum  <= 1'b0;
            sum_q     <= '0;
            blank_q   <= 1'b1;
            tx_load   <= 1'b0;
            tx_word   <= '0;
            tx_len    <= 3'd0;
            iss       <= 1'b0;
            iss_op    <= OP_READ;
            iss_addr  <= '0;
            iss_wdata <= '0;
        end else begin
            tx_load <= 1'b0;
            iss     <= 1'b0;
            if (op_done) begin
                pend <= 1'b0;
                unique case (state)
                    S_SCAN: begin
                        sum_q <= sum_q + 32'(op_rdata);
                        if (op_rdata != 8'hFF) blank_q <= 1'b0;
                        if (scan_addr == LAST_SCAN) begin
                            state   <= S_CMD;
                            tx_load <= 1'b1;
                            if (scan_sum) begin
                                tx_word <= sum_q + 32'(op_rdata);
                                tx_len  <= 3'd4;
                            end else begin
                                tx_word <= {24'h0, (blank_q && op_rdata == 8'hFF) ? RSP_ACK : RSP_NAK};
                                tx_len  <= 3'd1;
                            end
                        end else begin
                            scan_addr <= scan_addr + AW'(1);
                            iss       <= 1'b1;
                            iss_op    <= OP_READ;
                            iss_addr  <= 32'(scan_addr + AW'(1));
                            pend      <= 1'b1;
                        end
                    end
                    S_RD_WAIT: begin
                        state   <= S_CMD;
                        tx_load <= 1'b1;
                        tx_word <= {24'h0, op_rdata};
                        tx_len  <= 3'd1;
                    end
                    default: begin
                        state <= after_q;
                        if (ack_q) begin
                            tx_load <= 1'b1;
                            tx_word <= {24'h0, RSP_ACK};
                            tx_len  <= 3'd1;
                        end
                    end
                endcase
            end else if (state == S_MATCH) begin
                if (baud_locked) state <= S_INQ;
            end else if (take) begin
                // Default answer for a byte that completes a command: set below.
                unique case (state)
                    S_INQ: begin
                        tx_len <= 3'd1;
                        unique case (rx_data)
                            CMD_Q_SIZE: begin tx_load <= 1'b1; tx_word <= 32'(ARRAY_BYTES); tx_len <= 3'd4; end
                            CMD_Q_BASE: begin tx_load <= 1'b1; tx_word <= USER_BASE; tx_len <= 3'd4; end
                            CMD_Q_DEV:  begin tx_load <= 1'b1; tx_word <= {16'h0, DEVICE_ID}; tx_len <= 3'd2; end
                            CMD_GO_PE: begin
                                iss <= 1'b1; iss_op <= OP_FULL; iss_addr <= '0; pend <= 1'b1;
                                after_q <= S_CMD; ack_q <= 1'b1; state <= S_FERASE;
                            end
                            default: begin tx_load <= 1'b1; tx_word <= {24'h0, RSP_NAK}; end
                        endcase
                    end
                    S_CMD: begin
                        tx_len <= 3'd1;
                        unique case (rx_data)
                            CMD_PSEL: begin tx_load <= 1'b1; tx_word <= {24'h0, RSP_ACK}; state <= S_PROG_CODE; end
                            CMD_ESEL: begin tx_load <= 1'b1; tx_word <= {24'h0, RSP_ACK}; state <= S_ERA_CODE; end
                            CMD_STAT: begin tx_load <= 1'b1; tx_word <= {28'h0, state}; end
                            CMD_READ: begin cnt_q <= '0; state <= S_RD_ADDR; end
                            CMD_SUM, CMD_BLANK: begin
                                scan_sum <= (rx_data == CMD_SUM); sum_q <= '0; blank_q <= 1'b1;
                                scan_addr <= '0; iss <= 1'b1; iss_op <= OP_READ; iss_addr <= '0;
                                pend <= 1'b1; state <= S_SCAN;
                            end
                            default: begin tx_load <= 1'b1; tx_word <= {24'h0, RSP_NAK}; end
                        endcase
                    end
                    S_PROG_CODE: begin
                        if (rx_data == SEQ_PROG) begin
                            cnt_q <= '0; state <= S_PROG_ADDR;
                        end else begin
                            tx_load <= 1'b1; tx_word <= {24'h0, RSP_NAK}; tx_len <= 3'd1;
                        end
                    end
                    S_PROG_ADDR: begin
                        addr_q <= addr_nx;
                        cnt_q  <= cnt_q + CW'(1);
                        if (cnt_q == CW'(3)) begin
                            cnt_q <= '0;
                            if (addr_nx == 32'hFFFF_FFFF) begin
                                tx_load <= 1'b1; tx_word <= {24'h0, RSP_ACK}; tx_len <= 3'd1;
                                state <= S_CMD;
                            end else begin
                                state <= S_PROG_DATA;
                            end
                        end
                    end
                    S_PROG_DATA: begin
                        iss <= 1'b1; iss_op <= OP_PROG; iss_addr <= addr_q + 32'(cnt_q);
                        iss_wdata <= rx_data; pend <= 1'b1;
                        cnt_q <= cnt_q + CW'(1);
                        if (cnt_q == LAST_BYTE) begin
                            after_q <= S_PROG_CODE; ack_q <= 1'b1;
                        end else begin
                            after_q <= S_PROG_DATA; ack_q <= 1'b0;
                        end
                    end
                    S_ERA_CODE: begin
                        if (rx_data == SEQ_ERASE) begin
                            state <= S_ERA_BLK;
                        end else begin
                            tx_load <= 1'b1; tx_word <= {24'h0, RSP_NAK}; tx_len <= 3'd1;
                        end
                    end
                    S_ERA_BLK: begin
                        tx_len <= 3'd1;
                        if (rx_data == BLK_END) begin
                            tx_load <= 1'b1; tx_word <= {24'h0, RSP_ACK}; state <= S_CMD;
                        end else if (32'(rx_data) < 32'(NUM_BLOCKS)) begin
                            iss <= 1'b1; iss_op <= OP_BLK; iss_addr <= 32'(rx_data); pend <= 1'b1;
                            after_q <= S_ERA_CODE; ack_q <= 1'b1;
                        end else begin
                            tx_load <= 1'b1; tx_word <= {24'h0, RSP_NAK};
                        end
                    end
                    S_RD_ADDR: begin
                        addr_q <= addr_nx;
                        cnt_q  <= cnt_q + CW'(1);
                        if (cnt_q == CW'(3)) begin
                            cnt_q <= '0; iss <= 1'b1; iss_op <= OP_READ; iss_addr <= addr_nx;
                            pend <= 1'b1; state <= S_RD_WAIT;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/boot_cmd_sequencer.sv
// Top of the boot-mode command sequencer: wires the state machine to the
// response serializer and the flash request port. Assumes a flash side that
// answers each request with a one-cycle acknowledge.
module boot_cmd_sequencer
    import boot_seq_pkg::*;
#(
    parameter int          ARRAY_BYTES = 256,
    parameter int          NUM_BLOCKS  = 8,
    parameter int          PAYLOAD     = 128,
    parameter logic [31:0] USER_BASE   = 32'h0000_8000,
    parameter logic [15:0] DEVICE_ID   = 16'h0A31
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        baud_locked,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    output logic        rx_ready,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        fl_req,
    output logic [1:0]  fl_op,
    output logic [31:0] fl_addr,
    output logic [7:0]  fl_wdata,
    input  logic        fl_ack,
    input  logic [7:0]  fl_rdata
);
    logic        tx_busy;
    logic        tx_load;
    logic [31:0] tx_word;
    logic [2:0]  tx_len;
    logic        iss;
    flash_op_e   iss_op;
    logic [31:0] iss_addr;
    logic [7:0]  iss_wdata;
    logic        op_done;
    logic [7:0]  op_rdata;
    seq_state_e  phase;

    boot_seq_ctrl #(
        .ARRAY_BYTES(ARRAY_BYTES), .NUM_BLOCKS(NUM_BLOCKS), .PAYLOAD(PAYLOAD),
        .USER_BASE(USER_BASE), .DEVICE_ID(DEVICE_ID)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .baud_locked(baud_locked),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_busy(tx_busy), .tx_load(tx_load), .tx_word(tx_word), .tx_len(tx_len),
        .iss(iss), .iss_op(iss_op), .iss_addr(iss_addr), .iss_wdata(iss_wdata),
        .op_done(op_done), .op_rdata(op_rdata), .state(phase)
    );

    boot_tx_serializer u_tx (
        .clk(clk), .rst_n(rst_n), .load(tx_load), .load_word(tx_word),
        .load_len(tx_len), .tx_valid(tx_valid), .tx_data(tx_data), .busy(tx_busy)
    );

    boot_flash_port u_fp (
        .clk(clk), .rst_n(rst_n), .iss(iss), .iss_op(iss_op), .iss_addr(iss_addr),
        .iss_wdata(iss_wdata), .fl_req(fl_req), .fl_op(fl_op), .fl_addr(fl_addr),
        .fl_wdata(fl_wdata), .fl_ack(fl_ack), .fl_rdata(fl_rdata),
        .done(op_done), .rdata(op_rdata)
    );
endmodule

// File: rtl/boot_seq_checker.sv
// Protocol checker for the boot-mode command sequencer, bound to the top.
module boot_seq_checker
    import boot_seq_pkg::*;
#(
    parameter int NUM_BLOCKS = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  phase,
    input logic        rx_ready,
    input logic        tx_valid,
    input logic        fl_req,
    input logic [1:0]  fl_op,
    input logic [31:0] fl_addr,
    input logic        fl_ack
);
    // R1: nothing happens before the bit rate is locked
    p_quiet_unlocked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == S_MATCH) |-> (!rx_ready && !tx_valid && !fl_req));

    // R3: the operation pending during the forced erase is a full erase
    p_forced_full_erase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && phase == S_FERASE) |-> (fl_op == OP_FULL));

    // R13: request and its fields hold until acknowledged
    p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && !fl_ack) |=> (fl_req && $stable(fl_op) && $stable(fl_addr)));

    // R13: no host byte is taken while an operation is pending
    p_no_rx_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req |-> !rx_ready);

    // R13: no response byte while an operation is pending
    p_no_tx_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req |-> !tx_valid);

    // R9: block erase is only requested for an existing block
    p_blk_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && fl_op == OP_BLK) |-> (fl_addr < 32'(NUM_BLOCKS)));
endmodule

bind boot_cmd_sequencer boot_seq_checker #(.NUM_BLOCKS(NUM_BLOCKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .phase(phase), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .fl_req(fl_req), .fl_op(fl_op), .fl_addr(fl_addr),
    .fl_ack(fl_ack)
);

// File: tb/tb_boot_cmd_sequencer.sv
module tb_boot_cmd_sequencer;
    localparam int ARR = 256;
    localparam int BLK_BYTES = 32;
    localparam int ACK_DLY = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        baud_locked = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_ready, tx_valid, fl_req, fl_ack;
    logic [7:0]  tx_data, fl_wdata, fl_rdata;
    logic [1:0]  fl_op;
    logic [31:0] fl_addr;

    always #4 clk = ~clk;

    boot_cmd_sequencer dut (
        .clk(clk), .rst_n(rst_n), .baud_locked(baud_locked),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .fl_req(fl_req), .fl_op(fl_op),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_ack(fl_ack), .fl_rdata(fl_rdata)
    );

    int checks = 0, errors = 0;
    logic finished = 1'b0;

    // Flash model and request log
    logic [7:0]  mem [ARR];
    logic [7:0]  shadow [ARR];
    logic [31:0] plog_addr [256];
    logic [7:0]  plog_data [256];
    int n_full = 0, n_blk = 0, n_prog = 0, n_read = 0, dly = 0;
    int drop_viol = 0, busy_viol = 0;
    logic [31:0] last_blk = '0;
    logic req_q = 1'b0, ack_q = 1'b0;

    initial for (int i = 0; i < ARR; i++) mem[i] = 8'(i) ^ 8'h5A;

    always @(posedge clk) begin
        if (!rst_n) begin
            fl_ack <= 1'b0; fl_rdata <= 8'h00; dly = 0;
        end else begin
            if (req_q && !fl_req && !ack_q) drop_viol++;
            req_q <= fl_req; ack_q <= fl_ack;
            if (fl_req && !fl_ack) begin
                if (dly == ACK_DLY) begin
                    dly = 0;
                    fl_ack <= 1'b1;
                    fl_rdata <= mem[fl_addr[7:0]];
                    case (fl_op)
                        2'd0: begin for (int i = 0; i < ARR; i++) mem[i] = 8'hFF; n_full++; end
                        2'd1: begin
                            for (int i = 0; i < BLK_BYTES; i++) mem[fl_addr[2:0]*BLK_BYTES + i] = 8'hFF;
                            n_blk++; last_blk = fl_addr;
                        end
                        2'd2: begin
                            mem[fl_addr[7:0]] = fl_wdata;
                            if (n_prog < 256) begin plog_addr[n_prog] = fl_addr; plog_data[n_prog] = fl_wdata; end
                            n_prog++;
                        end
                        default: n_read++;
                    endcase
                end else dly++;
            end else fl_ack <= 1'b0;
        end
    end

    // Response capture and busy-rule monitor, away from the active edge
    logic [7:0] resp [16];
    int nresp = 0;
    always @(negedge clk) begin
        if (tx_valid) begin
            if (nresp < 16) resp[nresp] = tx_data;
            nresp++;
        end
        if (fl_req && rx_ready) busy_viol++;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] resp_word();
        logic [31:0] w = '0;
        for (int i = 0; i < nresp && i < 4; i++) w = {w[23:0], resp[i]};
        return w;
    endfunction

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_data = b; rx_valid = 1'b1;
        while (!rx_ready) @(negedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
        while (!rx_ready) @(negedge clk);
    endtask

    task automatic send_addr(input logic [31:0] a);
        for (int i = 3; i >= 0; i--) send(a[i*8 +: 8]);
    endtask

    task automatic expect_resp(input string req, input int len, input logic [31:0] exp);
        chk(nresp == len && resp_word() == exp, req, resp_word(), exp);
    endtask

    function automatic logic [31:0] shadow_sum();
        logic [31:0] s = '0;
        for (int i = 0; i < ARR; i++) s += 32'(shadow[i]);
        return s;
    endfunction

    // Stimulus table: {requirement number, command, response length, expected word}
    localparam int NV = 10;
    localparam logic [55:0] VEC [NV] = '{
        {8'd2,  8'h20, 8'd4, 32'h0000_0100},   // R2 size
        {8'd2,  8'h21, 8'd4, 32'h0000_8000},   // R2 base address
        {8'd2,  8'h22, 8'd2, 32'h0000_0A31},   // R2 device code
        {8'd4,  8'h43, 8'd1, 32'h0000_0015},   // R4 program select refused before erase
        {8'd9,  8'h77, 8'd1, 32'h0000_0015},   // R9 unknown code in inquiry
        {8'd3,  8'h40, 8'd1, 32'h0000_0006},   // R3 forced full erase
        {8'd14, 8'h4F, 8'd1, 32'h0000_0003},   // R14 status
        {8'd9,  8'h99, 8'd1, 32'h0000_0015},   // R9 unknown code in command wait
        {8'd11, 8'h4C, 8'd1, 32'h0000_0006},   // R11 blank after erase
        {8'd10, 8'h4B, 8'd4, 32'h0000_FF00}    // R10 sum of erased array
    };

    initial begin
        // Reset state
        repeat (3) @(negedge clk);
        chk(!rx_ready && !tx_valid && !fl_req, "R1 reset", {29'h0, rx_ready, tx_valid, fl_req}, 32'h0);
        rst_n = 1'b1;

        // R1: bytes offered before lock are not taken
        rx_valid = 1'b1; rx_data = 8'h20;
        begin
            int seen = 0;
            for (int i = 0; i < 20; i++) begin @(negedge clk); if (rx_ready) seen++; end
            chk(seen == 0 && nresp == 0 && n_full + n_read == 0, "R1", 32'(seen + nresp), 32'h0);
        end
        rx_valid = 1'b0;
        baud_locked = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            if (VEC[v][47:40] == 8'h40)   // R4: no flash work before the transition command
                chk(n_full + n_blk + n_prog + n_read == 0, "R4 no early op",
                    32'(n_full + n_blk + n_prog + n_read), 32'h0);
            nresp = 0;
            send(VEC[v][47:40]);
            chk(nresp == int'(VEC[v][39:32]) && resp_word() == VEC[v][31:0],
                $sformatf("R%0d table entry %0d", VEC[v][55:48], v), resp_word(), VEC[v][31:0]);
        end
        chk(n_full == 1, "R3 single full erase", 32'(n_full), 32'd1);
        for (int i = 0; i < ARR; i++) shadow[i] = 8'hFF;

        // R5: program one payload at 0x40
        nresp = 0; send(8'h43); expect_resp("R5 select", 1, 32'h06);
        nresp = 0; send(8'h50); send_addr(32'h0000_0040);
        for (int i = 0; i < 128; i++) begin
            send(8'(i * 7 + 3));
            shadow[64 + i] = 8'(i * 7 + 3);
        end
        expect_resp("R5 ack", 1, 32'h06);
        begin
            int bad = 0;
            for (int i = 0; i < 128; i++)
                if (plog_addr[i] != 32'(64 + i) || plog_data[i] != 8'(i * 7 + 3)) bad++;
            chk(n_prog == 128 && bad == 0, "R5 writes", 32'(n_prog * 1000 + bad), 32'd128000);
        end

        // R6: sentinel address ends programming
        nresp = 0; send(8'h50); send_addr(32'hFFFF_FFFF);
        expect_resp("R6 ack", 1, 32'h06);
        chk(n_prog == 128, "R6 no write", 32'(n_prog), 32'd128);
        nresp = 0; send(8'h4F); expect_resp("R6 status", 1, 32'h03);

        // R12: single read
        nresp = 0; send(8'h52); send_addr(32'h0000_0045);
        expect_resp("R12 read", 1, 32'h26);

        // R10 / R11 after programming
        nresp = 0; send(8'h4B); expect_resp("R10 sum", 4, shadow_sum());
        nresp = 0; send(8'h4C); expect_resp("R11 not blank", 1, 32'h15);

        // R7 / R9 / R8: erase sequences
        nresp = 0; send(8'h48); expect_resp("R7 select", 1, 32'h06);
        nresp = 0; send(8'h33); expect_resp("R9 bad seq code", 1, 32'h15);
        nresp = 0; send(8'h45); send(8'h09); expect_resp("R9 block out of range", 1, 32'h15);
        chk(n_blk == 0, "R9 no erase", 32'(n_blk), 32'd0);
        nresp = 0; send(8'h02); expect_resp("R7 ack", 1, 32'h06);  // state kept: byte is a block number
        chk(n_blk == 1 && last_blk == 32'd2, "R7 block op", last_blk, 32'd2);
        for (int i = 64; i < 96; i++) shadow[i] = 8'hFF;
        nresp = 0; send(8'h45); send(8'h01); expect_resp("R7 repeat", 1, 32'h06);
        for (int i = 32; i < 64; i++) shadow[i] = 8'hFF;
        nresp = 0; send(8'h45); send(8'hFF); expect_resp("R8 ack", 1, 32'h06);
        chk(n_blk == 2, "R8 no erase", 32'(n_blk), 32'd2);
        nresp = 0; send(8'h4F); expect_resp("R8 status", 1, 32'h03);
        nresp = 0; send(8'h4B); expect_resp("R10 sum after erase", 4, shadow_sum());

        // R13: handshake discipline over the whole run
        chk(drop_viol == 0, "R13 req held", 32'(drop_viol), 32'd0);
        chk(busy_viol == 0, "R13 rx blocked", 32'(busy_viol), 32'd0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule